// File: doc/BRIEF.md
# Receive Error Statistics Counters

This block keeps three wrap-around event counters for a network receiver: bad-CRC frames, misaligned frames (frames that end with dribbling bits) and frames dropped for lack of buffers or because of an overrun. At the end of each received frame the receive path presents a status bundle for one cycle. A fixed exclusion order then picks which single counter, if any, that frame advances.

Software reads the counters through a small register port. It can preset them, for example to clear them, but only while the channel is disabled. A write issued while the channel is enabled is dropped.

Top module: `rx_err_stats`

## Requirements
- R1: Synchronous active-high reset clears all three counters to zero.
- R2: A frame end with `st_no_buf` or `st_overrun` set increments the discard counter, whatever the CRC, dribble and address flags say.
- R3: A frame end with `st_dribble` set, `st_addr_ok` set and neither discard cause present increments the alignment counter.
- R4: A frame end with `st_crc_bad` set, `st_addr_ok` set, and no dribble or discard cause present increments the CRC counter.
- R5: A frame end with `st_addr_ok` clear and no discard cause leaves every counter unchanged.
- R6: Each frame end increments at most one counter, chosen in the order discard, then alignment, then CRC. Cycles without `frame_end` leave the counters unchanged unless a write applies.
- R7: Every counter wraps from all ones to zero (modulo 2^CNT_W, with CNT_W defaulting to 32).
- R8: With `chan_en` low, `reg_wr` loads `reg_wdata` into the counter selected by `reg_addr`. Address 0 selects the CRC counter, 1 the alignment counter and 2 the discard counter. Address 3 selects nothing.
- R9: With `chan_en` high, `reg_wr` has no effect on any counter.
- R10: When an applied write and a frame end fall in the same cycle, the written counter takes the written value. The other counters follow the frame rules.
- R11: `reg_rdata` shows, combinationally, the counter selected by `reg_addr` using the encoding of R8. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enabled; blocks software writes |
| frame_end | input | 1 | One-cycle strobe: status bundle valid |
| st_addr_ok | input | 1 | Frame addressed to this station |
| st_no_buf | input | 1 | Frame received with no buffer available |
| st_overrun | input | 1 | Frame suffered a receive overrun |
| st_dribble | input | 1 | Frame ended with dribbling bits |
| st_crc_bad | input | 1 | Frame CRC check failed |
| reg_wr | input | 1 | Software write strobe |
| reg_addr | input | 2 | Counter select for read and write |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| crc_count | output | CNT_W | CRC error counter |
| align_count | output | CNT_W | Alignment error counter |
| discard_count | output | CNT_W | Discarded frame counter |

## Verification
The bench builds the block with CNT_W = 8. At that width, wraparound can be reached both by counting up from a preset value and by a long random run, with no need for 2^32 events. The narrow width leaves the exclusion order and the write gating unchanged, because they do not depend on width. A random phase sweeps all 32 combinations of the status flags against a behavioural model. It covers frame ends that coincide with writes while the channel is disabled, and writes attempted while it is enabled.

// File: rtl/rx_err_stats_pkg.sv
package rx_err_stats_pkg;

    localparam int NUM_CNT  = 3;
    localparam int ADDR_W   = 2;

    // Counter indices double as register addresses
    localparam int IDX_CRC   = 0;
    localparam int IDX_ALIGN = 1;
    localparam int IDX_DISC  = 2;

    typedef struct packed {
        logic addr_ok;
        logic no_buf;
        logic overrun;
        logic dribble;
        logic crc_bad;
    } frame_stat_t;

    typedef enum logic [1:0] {
        HIT_NONE    = 2'd0,
        HIT_CRC     = 2'd1,
        HIT_ALIGN   = 2'd2,
        HIT_DISCARD = 2'd3
    } hit_t;

    // Exclusion order: discard causes dominate, then address filter,
    // then alignment, then CRC.
    function automatic hit_t classify(input frame_stat_t s);
        if (s.no_buf || s.overrun)
            return HIT_DISCARD;
        else if (!s.addr_ok)
            return HIT_NONE;
        else if (s.dribble)
            return HIT_ALIGN;
        else if (s.crc_bad)
            return HIT_CRC;
        else
            return HIT_NONE;
    endfunction

    function automatic hit_t hit_of_index(input int idx);
        case (idx)
            IDX_CRC:   return HIT_CRC;
            IDX_ALIGN: return HIT_ALIGN;
            IDX_DISC:  return HIT_DISCARD;
            default:   return HIT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rx_err_classify.sv
module rx_err_classify
    import rx_err_stats_pkg::*;
(
    input  logic                frame_end,
    input  frame_stat_t         stat,
    output logic [NUM_CNT-1:0]  inc
);

    hit_t hit;

    always_comb begin
        hit = frame_end ? classify(stat) : HIT_NONE;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_inc
        assign inc[i] = (hit == hit_of_index(i));
    end

endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (inc)
            q <= q + CNT_W'(1);
    end

endmodule

// File: rtl/rx_err_regif.sv
module rx_err_regif
    import rx_err_stats_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                chan_en,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CNT_W-1:0]    cnt [NUM_CNT],
    output logic [NUM_CNT-1:0]  load,
    output logic [CNT_W-1:0]    rdata
);

    logic wr_ok;
    assign wr_ok = reg_wr && !chan_en;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        assign load[i] = wr_ok && (reg_addr == ADDR_W'(i));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(i))
                rdata = cnt[i];
        end
    end

endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
    import rx_err_stats_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              frame_end,
    input  logic              st_addr_ok,
    input  logic              st_no_buf,
    input  logic              st_overrun,
    input  logic              st_dribble,
    input  logic              st_crc_bad,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [CNT_W-1:0]  crc_count,
    output logic [CNT_W-1:0]  align_count,
    output logic [CNT_W-1:0]  discard_count
);

    frame_stat_t         stat;
    logic [NUM_CNT-1:0]  inc;
    logic [NUM_CNT-1:0]  load;
    logic [CNT_W-1:0]    cnt [NUM_CNT];

    assign stat = '{addr_ok: st_addr_ok, no_buf: st_no_buf,
                    overrun: st_overrun, dribble: st_dribble,
                    crc_bad: st_crc_bad};

    rx_err_classify u_classify (
        .frame_end (frame_end),
        .stat      (stat),
        .inc       (inc)
    );

    rx_err_regif #(.CNT_W(CNT_W)) u_regif (
        .chan_en  (chan_en),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .cnt      (cnt),
        .load     (load),
        .rdata    (reg_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        rx_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .inc      (inc[i]),
            .load     (load[i]),
            .load_val (reg_wdata),
            .q        (cnt[i])
        );
    end

    assign crc_count     = cnt[IDX_CRC];
    assign align_count   = cnt[IDX_ALIGN];
    assign discard_count = cnt[IDX_DISC];

endmodule

// File: rtl/rx_err_stats_chk.sv
module rx_err_stats_chk #(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              chan_en,
    input logic              frame_end,
    input logic              st_addr_ok,
    input logic              st_no_buf,
    input logic              st_overrun,
    input logic              st_dribble,
    input logic              st_crc_bad,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic [CNT_W-1:0]  reg_rdata,
    input logic [CNT_W-1:0]  crc_count,
    input logic [CNT_W-1:0]  align_count,
    input logic [CNT_W-1:0]  discard_count
);

    logic drop, wr_live;
    assign drop    = st_no_buf || st_overrun;
    assign wr_live = reg_wr && !chan_en;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (crc_count == '0 && align_count == '0 && discard_count == '0));

    p_discard_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_end && drop && !wr_live) |=>
        discard_count == $past(discard_count) + CNT_W'(1));

    p_align_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !drop && st_addr_ok && st_dribble && !wr_live) |=>
        align_count == $past(align_count) + CNT_W'(1));

    p_crc_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !drop && st_addr_ok && !st_dribble && st_crc_bad && !wr_live) |=>
        crc_count == $past(crc_count) + CNT_W'(1));

    p_excl_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_end && drop && !wr_live) |=>
        ($stable(crc_count) && $stable(align_count)));

    p_unaddressed_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !drop && !st_addr_ok && !wr_live) |=>
        ($stable(crc_count) && $stable(align_count) && $stable(discard_count)));

    p_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !frame_end) |=>
        ($stable(crc_count) && $stable(align_count) && $stable(discard_count)));

    p_write_crc_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_live && reg_addr == 2'd0) |=> crc_count == $past(reg_wdata));

    p_read_spare_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> reg_rdata == '0);

endmodule

bind rx_err_stats rx_err_stats_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .chan_en       (chan_en),
    .frame_end     (frame_end),
    .st_addr_ok    (st_addr_ok),
    .st_no_buf     (st_no_buf),
    .st_overrun    (st_overrun),
    .st_dribble    (st_dribble),
    .st_crc_bad    (st_crc_bad),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .crc_count     (crc_count),
    .align_count   (align_count),
    .discard_count (discard_count)
);

// File: tb/tb_rx_err_stats.sv
module tb_rx_err_stats;

    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         chan_en = 1'b0;
    logic         frame_end = 1'b0;
    logic         st_addr_ok = 1'b0, st_no_buf = 1'b0, st_overrun = 1'b0;
    logic         st_dribble = 1'b0, st_crc_bad = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata, crc_count, align_count, discard_count;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // Behavioural reference counters
    logic [W-1:0] m_crc = '0, m_aln = '0, m_dsc = '0;

    always #(PERIOD/2) clk = ~clk;

    rx_err_stats #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .frame_end(frame_end),
        .st_addr_ok(st_addr_ok), .st_no_buf(st_no_buf), .st_overrun(st_overrun),
        .st_dribble(st_dribble), .st_crc_bad(st_crc_bad),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .crc_count(crc_count),
        .align_count(align_count), .discard_count(discard_count)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_crc <= '0; m_aln <= '0; m_dsc <= '0;
        end else begin
            logic [W-1:0] c, a, d;
            c = m_crc; a = m_aln; d = m_dsc;
            if (frame_end) begin
                if (st_no_buf || st_overrun) d = d + 1'b1;
                else if (st_addr_ok && st_dribble) a = a + 1'b1;
                else if (st_addr_ok && st_crc_bad) c = c + 1'b1;
            end
            if (reg_wr && !chan_en) begin
                if (reg_addr == 2'd0) c = reg_wdata;
                if (reg_addr == 2'd1) a = reg_wdata;
                if (reg_addr == 2'd2) d = reg_wdata;
            end
            m_crc <= c; m_aln <= a; m_dsc <= d;
        end
    end

    task automatic check(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare state from the previous edge, then drive the next inputs
    task automatic step(input string t, input logic fe, input logic [4:0] st,
                        input logic wr, input logic [1:0] ad, input logic [W-1:0] wd,
                        input logic en);
        logic [W-1:0] exp_rd;
        @(negedge clk);
        check("crc_count", crc_count, m_crc);
        check("align_count", align_count, m_aln);
        check("discard_count", discard_count, m_dsc);
        case (reg_addr)
            2'd0: exp_rd = m_crc;
            2'd1: exp_rd = m_aln;
            2'd2: exp_rd = m_dsc;
            default: exp_rd = '0;
        endcase
        check("reg_rdata", reg_rdata, exp_rd);
        tag = t;
        frame_end = fe;
        {st_addr_ok, st_no_buf, st_overrun, st_dribble, st_crc_bad} = st;
        reg_wr = wr; reg_addr = ad; reg_wdata = wd; chan_en = en;
    endtask

    // Status bits: {addr_ok, no_buf, overrun, dribble, crc_bad}
    initial begin
        step("R1", 0, 5'b0, 0, 2'd0, '0, 0);
        step("R1", 0, 5'b0, 0, 2'd1, '0, 0);
        rst = 1'b0;
        step("R1", 0, 5'b0, 0, 2'd2, '0, 1);
        step("R2", 1, 5'b11001, 0, 2'd2, '0, 1);   // no_buf with bad CRC
        step("R2", 1, 5'b00101, 0, 2'd2, '0, 1);   // overrun, unaddressed
        step("R3", 1, 5'b10011, 0, 2'd1, '0, 1);   // dribble + bad CRC
        step("R4", 1, 5'b10001, 0, 2'd0, '0, 1);   // bad CRC only
        step("R5", 1, 5'b00011, 0, 2'd0, '0, 1);   // unaddressed
        step("R6", 1, 5'b11111, 0, 2'd0, '0, 1);   // all flags set
        step("R6", 0, 5'b11111, 0, 2'd0, '0, 1);   // no strobe
        step("R9", 0, 5'b0, 1, 2'd0, 8'h55, 1);    // write while enabled
        step("R9", 0, 5'b0, 1, 2'd2, 8'h66, 1);
        step("R8", 0, 5'b0, 1, 2'd0, 8'hFE, 0);
        step("R8", 0, 5'b0, 1, 2'd1, 8'hFF, 0);
        step("R8", 0, 5'b0, 1, 2'd2, 8'hFF, 0);
        step("R7", 1, 5'b10001, 0, 2'd0, '0, 1);
        step("R7", 1, 5'b10001, 0, 2'd0, '0, 1);   // crc wraps FF->00
        step("R7", 1, 5'b10010, 0, 2'd1, '0, 1);   // align wraps
        step("R7", 1, 5'b01000, 0, 2'd2, '0, 1);   // discard wraps
        step("R10", 1, 5'b01000, 1, 2'd2, 8'h40, 0); // write beats frame
        step("R10", 1, 5'b10001, 1, 2'd1, 8'h20, 0); // other counter counts
        step("R11", 0, 5'b0, 0, 2'd3, '0, 0);
        step("R11", 0, 5'b0, 1, 2'd3, 8'h77, 0);     // spare address
        for (int i = 0; i < 3000; i++) begin
            step("R6", 1'($urandom), 5'($urandom), 1'($urandom_range(0, 7) == 0),
                 2'($urandom), W'($urandom), 1'($urandom));
        end
        step("R6", 0, 5'b0, 0, 2'd0, '0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule